// File: doc/BRIEF.md
# Raw-Frame Ring Buffer Pointer Manager

This block owns the transmit and receive byte rings of one raw-frame socket and the pointers that walk them. The host reaches it through a byte-wide register bus. It fills the transmit ring directly, moves the transmit write pointer forward and then issues a send command. The block streams the bytes between its read pointer and that write pointer to the MAC side, one byte per handshake. Incoming frames from the MAC side are written into the receive ring, each one behind a two-byte big-endian length header. The host drains a frame, moves the receive read pointer and issues a release command to free the space.

All pointers are free-running 16-bit counters. Only their low `RING_AW` bits index a ring. Ring size is `RING_BYTES = 2**RING_AW`; `RING_AW = 13` gives the 8 KB rings of a full-size build. Ring data sits in simple dual-port memories, so block RAM can be inferred for them. A received frame becomes visible to the host only once its last byte has been stored. A frame that does not fit is discarded whole.

Top module: `frame_ring_ctrl`

## Requirements
- R1: After reset the transmit read and write pointers, the receive committed, released and pending pointers and both event bits are zero. TX free size reads `RING_BYTES` and `tx_valid` is low.
- R2: The 16-bit registers are big-endian, with the high byte at the even address: TX free size 0x0420, TX read pointer 0x0422, TX write pointer 0x0424, RX size 0x0426, RX read pointer 0x0428. A host read returns data with `host_rvalid` one cycle after `host_rd`. Reading a high byte captures the whole 16-bit value, and a following low-byte read returns the captured low half, even if the register has changed in between.
- R3: Writing the high byte of the TX write pointer or the RX read pointer only stages it. Writing the low byte loads {staged, low} into the register, and the new value reads back.
- R4: TX free size always equals `RING_BYTES - (write - read)`, taken modulo 2**16.
- R5: A host write to `TX_BASE + (p mod RING_BYTES)` sets the byte that is sent when the transmit read pointer equals p. Reads at `RX_BASE + (p mod RING_BYTES)` return the receive ring byte for pointer p, wrapping at the ring end.
- R6: Writing 0x20 to 0x0401 (send) sends, in order, the bytes from the read pointer up to the write pointer as it stood at the command. `tx_data` is held while `tx_valid` is high and `tx_ready` is low. The read pointer advances by one per accepted byte. A send issued while a transfer is running is ignored.
- R7: Bit 4 of the event register at 0x0402 is set when the read pointer reaches the end of a send. It is set at once if the two pointers are already equal. Writing a 1 to the bit clears it.
- R8: An accepted frame of payload length L is stored at the committed pointer as header bytes (L+2)>>8 and (L+2)&0xFF, followed by the payload. RX size grows by L+2 only after the last byte is stored, and bit 2 of 0x0402 is then set (writing a 1 clears it). The first payload byte may arrive no earlier than two cycles after `rx_sof`.
- R9: A frame with L+2 greater than `RING_BYTES - (committed - released)` is dropped whole. No pointer or size changes and bit 2 is not set. A frame that fills the ring exactly is accepted.
- R10: A write to the RX read pointer does not change RX size or free space until 0x40 (release) is written to 0x0401. RX size then reads committed minus the new pointer.
- R11: RX size reads zero when no unread data remains.
- R12: Command codes other than 0x20 and 0x40, and writes to the TX free size, TX read pointer or RX size registers, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| tx_data | output | 8 | Byte to the MAC side |
| tx_valid | output | 1 | tx_data is valid |
| tx_ready | input | 1 | MAC side accepts tx_data |
| rx_sof | input | 1 | Start of an incoming frame |
| rx_len | input | 16 | Payload length, sampled with rx_sof |
| rx_valid | input | 1 | rx_byte is valid |
| rx_byte | input | 8 | Incoming payload byte |

## Verification
The bench builds the block with `RING_AW = 6`, which gives 64-byte rings. With rings this small, a few dozen random frames and sends carry the pointers around the ring end many times, so index wrap is exercised by ordinary traffic. The small size also brings the drop boundary within reach: an exact fill and a frame one header too large come from only three or four frames. The remaining parameters stay at their defaults, so the register offsets and ring bases are the ones a full-size build uses.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;
  localparam logic [15:0] OFS_CMD    = 16'h0401;
  localparam logic [15:0] OFS_EVT    = 16'h0402;
  localparam logic [15:0] OFS_TXFREE = 16'h0420;
  localparam logic [15:0] OFS_TXRD   = 16'h0422;
  localparam logic [15:0] OFS_TXWR   = 16'h0424;
  localparam logic [15:0] OFS_RXSIZE = 16'h0426;
  localparam logic [15:0] OFS_RXRD   = 16'h0428;

  localparam logic [7:0] CMD_SEND = 8'h20;
  localparam logic [7:0] CMD_RECV = 8'h40;

  localparam int EVT_SENT_BIT = 4;
  localparam int EVT_RECV_BIT = 2;

  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_SHOW} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_BODY, RX_SKIP} rx_state_t;
endpackage

// File: rtl/frame_ring_ram.sv
module frame_ring_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/frame_ring_tx.sv
module frame_ring_tx
  import frame_ring_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int RING_AW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               send,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic               tx_ready,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic               mem_re,
  output logic [RING_AW-1:0] mem_addr,
  output logic               tx_valid,
  output logic               done
);
  tx_state_t        st;
  logic [PTR_W-1:0] end_q;
  logic [PTR_W-1:0] rd_next;

  assign rd_next  = rd_ptr + 1'b1;
  assign mem_re   = (st == TX_FETCH);
  assign mem_addr = rd_ptr[RING_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      rd_ptr   <= '0;
      end_q    <= '0;
      tx_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: begin
          if (send) begin
            end_q <= wr_ptr;
            if (wr_ptr == rd_ptr) done <= 1'b1;
            else                  st   <= TX_FETCH;
          end
        end
        TX_FETCH: begin
          st       <= TX_SHOW;
          tx_valid <= 1'b1;
        end
        TX_SHOW: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            rd_ptr   <= rd_next;
            if (rd_next == end_q) begin
              done <= 1'b1;
              st   <= TX_IDLE;
            end else begin
              st <= TX_FETCH;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_ring_rx.sv
module frame_ring_rx
  import frame_ring_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int RING_AW = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_sof,
  input  logic [PTR_W-1:0]   rx_len,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic [PTR_W-1:0]   rel_ptr,
  output logic [PTR_W-1:0]   wr_ptr,
  output logic               mem_we,
  output logic [RING_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               done,
  output logic               drop
);
  localparam logic [PTR_W:0] RING_BYTES = (PTR_W+1)'(1) << RING_AW;

  rx_state_t        st;
  logic [PTR_W-1:0] cur;
  logic [PTR_W-1:0] rem;
  logic [15:0]      need_q;
  logic [PTR_W:0]   need_w;
  logic [PTR_W:0]   free_w;
  logic [PTR_W-1:0] used;
  logic             fits;

  assign used   = wr_ptr - rel_ptr;
  assign need_w = {1'b0, rx_len} + (PTR_W+1)'(2);
  assign free_w = RING_BYTES - {1'b0, used};
  assign fits   = (need_w <= free_w);

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = cur[RING_AW-1:0];
    mem_wdata = rx_byte;
    case (st)
      RX_IDLE: begin
        if (rx_sof && fits) begin
          mem_we    = 1'b1;
          mem_addr  = wr_ptr[RING_AW-1:0];
          mem_wdata = need_w[15:8];
        end
      end
      RX_HDR: begin
        mem_we    = 1'b1;
        mem_wdata = need_q[7:0];
      end
      RX_BODY: mem_we = rx_valid;
      default: mem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= RX_IDLE;
      cur    <= '0;
      rem    <= '0;
      need_q <= '0;
      wr_ptr <= '0;
      done   <= 1'b0;
      drop   <= 1'b0;
    end else begin
      done <= 1'b0;
      drop <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (rx_sof) begin
            rem <= rx_len;
            if (fits) begin
              need_q <= need_w[15:0];
              cur    <= wr_ptr + 1'b1;
              st     <= RX_HDR;
            end else begin
              drop <= 1'b1;
              if (rx_len != '0) st <= RX_SKIP;
            end
          end
        end
        RX_HDR: begin
          cur <= cur + 1'b1;
          if (rem == '0) begin
            wr_ptr <= cur + 1'b1;
            done   <= 1'b1;
            st     <= RX_IDLE;
          end else begin
            st <= RX_BODY;
          end
        end
        RX_BODY: begin
          if (rx_valid) begin
            cur <= cur + 1'b1;
            rem <= rem - 1'b1;
            if (rem == PTR_W'(1)) begin
              wr_ptr <= cur + 1'b1;
              done   <= 1'b1;
              st     <= RX_IDLE;
            end
          end
        end
        RX_SKIP: begin
          if (rx_valid) begin
            rem <= rem - 1'b1;
            if (rem == PTR_W'(1)) st <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl
  import frame_ring_pkg::*;
#(
  parameter int          PTR_W   = 16,
  parameter int          RING_AW = 11,
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] TX_BASE = 16'h4000,
  parameter logic [15:0] RX_BASE = 16'h6000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] host_addr,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  input  logic        host_rd,
  output logic [7:0]  host_rdata,
  output logic        host_rvalid,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        rx_sof,
  input  logic [15:0] rx_len,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte
);
  localparam logic [PTR_W-1:0] RING_BYTES = PTR_W'(1) << RING_AW;
  localparam int               RGN_W      = ADDR_W - RING_AW;

  logic [PTR_W-1:0]   tx_wr_q, tx_rd_w, tx_free;
  logic [PTR_W-1:0]   rx_wr_w, rx_rel_q, rx_rd_pend, rx_size;
  logic [7:0]         stage_q, snap_q, rdata_q, rx_dout;
  logic               ev_sent_q, ev_recv_q, rvalid_q, from_ram_q;
  logic               in_tx, in_rx, send_p, recv_p, evt_wr;
  logic               tx_done_w, rx_done_w, rx_drop_w;
  logic               tx_re_w, rx_we_w;
  logic [RING_AW-1:0] tx_raddr_w, rx_waddr_w;
  logic [7:0]         rx_wdata_w;
  logic [PTR_W-1:0]   reg16;
  logic               is16;

  assign in_tx   = (host_addr[ADDR_W-1:RING_AW] == TX_BASE[ADDR_W-1:RING_AW]);
  assign in_rx   = (host_addr[ADDR_W-1:RING_AW] == RX_BASE[ADDR_W-1:RING_AW]);
  assign send_p  = host_wr && (host_addr == OFS_CMD) && (host_wdata == CMD_SEND);
  assign recv_p  = host_wr && (host_addr == OFS_CMD) && (host_wdata == CMD_RECV);
  assign evt_wr  = host_wr && (host_addr == OFS_EVT);
  assign tx_free = RING_BYTES - (tx_wr_q - tx_rd_w);
  assign rx_size = rx_wr_w - rx_rel_q;

  // ring storage: host fills TX, receiver fills RX
  frame_ring_ram #(.AW(RING_AW), .DW(8)) u_tx_ram (
    .clk(clk), .we(host_wr && in_tx), .waddr(host_addr[RING_AW-1:0]),
    .wdata(host_wdata), .re(tx_re_w), .raddr(tx_raddr_w), .rdata(tx_data)
  );

  frame_ring_ram #(.AW(RING_AW), .DW(8)) u_rx_ram (
    .clk(clk), .we(rx_we_w), .waddr(rx_waddr_w), .wdata(rx_wdata_w),
    .re(host_rd && in_rx), .raddr(host_addr[RING_AW-1:0]), .rdata(rx_dout)
  );

  frame_ring_tx #(.PTR_W(PTR_W), .RING_AW(RING_AW)) u_tx (
    .clk(clk), .rst(rst), .send(send_p), .wr_ptr(tx_wr_q), .tx_ready(tx_ready),
    .rd_ptr(tx_rd_w), .mem_re(tx_re_w), .mem_addr(tx_raddr_w),
    .tx_valid(tx_valid), .done(tx_done_w)
  );

  frame_ring_rx #(.PTR_W(PTR_W), .RING_AW(RING_AW)) u_rx (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_len(PTR_W'(rx_len)),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rel_ptr(rx_rel_q),
    .wr_ptr(rx_wr_w), .mem_we(rx_we_w), .mem_addr(rx_waddr_w),
    .mem_wdata(rx_wdata_w), .done(rx_done_w), .drop(rx_drop_w)
  );

  // 16-bit register selected by the even address of the pair
  always_comb begin
    is16  = 1'b1;
    reg16 = '0;
    case ({host_addr[15:1], 1'b0})
      OFS_TXFREE: reg16 = tx_free;
      OFS_TXRD:   reg16 = tx_rd_w;
      OFS_TXWR:   reg16 = tx_wr_q;
      OFS_RXSIZE: reg16 = rx_size;
      OFS_RXRD:   reg16 = rx_rd_pend;
      default:    is16  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wr_q    <= '0;
      rx_rel_q   <= '0;
      rx_rd_pend <= '0;
      stage_q    <= '0;
      snap_q     <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
      ev_sent_q  <= 1'b0;
      ev_recv_q  <= 1'b0;
    end else begin
      if (host_wr) begin
        case (host_addr)
          OFS_TXWR:         stage_q    <= host_wdata;
          OFS_TXWR + 16'd1: tx_wr_q    <= {stage_q, host_wdata};
          OFS_RXRD:         stage_q    <= host_wdata;
          OFS_RXRD + 16'd1: rx_rd_pend <= {stage_q, host_wdata};
          default: ;
        endcase
      end
      if (recv_p) rx_rel_q <= rx_rd_pend;

      ev_sent_q <= tx_done_w | (ev_sent_q & ~(evt_wr & host_wdata[EVT_SENT_BIT]));
      ev_recv_q <= rx_done_w | (ev_recv_q & ~(evt_wr & host_wdata[EVT_RECV_BIT]));

      rvalid_q   <= host_rd;
      from_ram_q <= host_rd && in_rx;
      if (host_rd && !in_rx) begin
        if (host_addr == OFS_EVT) begin
          rdata_q <= 8'(({7'd0, ev_sent_q} << EVT_SENT_BIT) |
                        ({7'd0, ev_recv_q} << EVT_RECV_BIT));
        end else if (is16 && !host_addr[0]) begin
          rdata_q <= reg16[15:8];
          snap_q  <= reg16[7:0];
        end else if (is16) begin
          rdata_q <= snap_q;
        end else begin
          rdata_q <= '0;
        end
      end
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = from_ram_q ? rx_dout : rdata_q;
endmodule

// File: rtl/frame_ring_chk.sv
module frame_ring_chk #(
  parameter int PTR_W   = 16,
  parameter int RING_AW = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             host_rd,
  input logic             host_rvalid,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic [PTR_W-1:0] tx_rd,
  input logic [PTR_W-1:0] rx_wr,
  input logic [PTR_W-1:0] rx_rel,
  input logic             rx_drop
);
  localparam logic [PTR_W-1:0] RING_BYTES = PTR_W'(1) << RING_AW;

  // R2
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  // R2
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R6
  tx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (tx_rd == $past(tx_rd) + 1'b1));
  // R6
  tx_rd_still_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && tx_ready) |=> $stable(tx_rd));
  // R9
  drop_keep_chk: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> $stable(rx_wr));
  // R11
  rx_space_chk: assert property (@(posedge clk) disable iff (rst)
    (PTR_W'(rx_wr - rx_rel) <= RING_BYTES));
endmodule

bind frame_ring_ctrl frame_ring_chk #(.PTR_W(PTR_W), .RING_AW(RING_AW)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_rvalid(host_rvalid),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_rd(tx_rd_w), .rx_wr(rx_wr_w), .rx_rel(rx_rel_q), .rx_drop(rx_drop_w)
);

// File: tb/tb_frame_ring_ctrl.sv
module tb_frame_ring_ctrl;
  localparam int          AW    = 6;
  localparam int          RB    = 1 << AW;
  localparam logic [15:0] MSK   = 16'(RB - 1);
  localparam logic [15:0] TXB   = 16'h4000;
  localparam logic [15:0] RXB   = 16'h6000;
  localparam logic [15:0] A_CMD = 16'h0401, A_EVT = 16'h0402, A_FREE = 16'h0420,
                          A_TRD = 16'h0422, A_TWR = 16'h0424, A_RSZ = 16'h0426,
                          A_RRD = 16'h0428;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0;
  logic [15:0] rx_len = '0;
  logic [7:0]  rx_byte = '0;

  always #2.5 clk = ~clk;

  frame_ring_ctrl #(.RING_AW(AW)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 0, sink_en = 1;
  logic [7:0]  exp_tx [0:511];
  logic [7:0]  cap [0:511];
  int          cap_n = 0;
  logic [7:0]  rxm [0:RB-1];
  logic [15:0] m_txwr = '0, m_rxwr = '0, m_rxrel = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [15:0] tx_free_exp(input logic [15:0] w, input logic [15:0] r);
    return 16'(RB) - (w - r);
  endfunction

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    chk("R2 rvalid after read", host_rvalid, 1'b1);
    d = host_rdata;
  endtask

  task automatic read16(input logic [15:0] a, output logic [15:0] v);
    logic [7:0] hi, lo;
    hread(a, hi); hread(a + 16'd1, lo);
    v = {hi, lo};
  endtask

  task automatic write16(input logic [15:0] a, input logic [15:0] v);
    hwrite(a, v[15:8]); hwrite(a + 16'd1, v[7:0]);
  endtask

  // MAC-side sink with random back-pressure
  initial forever begin
    @(negedge clk);
    tx_ready = sink_en ? (($urandom % 4) != 0) : 1'b0;
    if (tx_valid && tx_ready) begin
      cap[cap_n] = tx_data;
      cap_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic wait_sent();
    logic [7:0] e = '0;
    for (int i = 0; i < 600; i++) begin
      hread(A_EVT, e);
      if (e[4]) break;
    end
    chk("R7 send-complete bit", e[4], 1'b1);
    hwrite(A_EVT, 8'h10);
    hread(A_EVT, e);
    chk("R7 send-complete cleared", e[4], 1'b0);
  endtask

  task automatic fill_tx(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      exp_tx[base + i] = b;
      hwrite(TXB + ((m_txwr + 16'(i)) & MSK), b);
    end
  endtask

  task automatic rx_frame(input int len, output bit acc);
    logic [15:0] need, used;
    need = 16'(len + 2);
    used = m_rxwr - m_rxrel;
    acc = (need <= 16'(RB) - used);
    if (acc) begin
      rxm[m_rxwr & MSK] = need[15:8];
      rxm[(m_rxwr + 16'd1) & MSK] = need[7:0];
    end
    @(negedge clk); rx_sof = 1'b1; rx_len = 16'(len);
    @(negedge clk); rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (($urandom % 3) == 0) begin
        rx_valid = 1'b0;
        @(negedge clk);
      end
      rx_valid = 1'b1; rx_byte = 8'($urandom);
      if (acc) rxm[(m_rxwr + 16'd2 + 16'(i)) & MSK] = rx_byte;
    end
    @(negedge clk); rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (acc) m_rxwr = m_rxwr + need;
  endtask

  task automatic drain();
    logic [15:0] v, hdr;
    logic [7:0]  b;
    while (m_rxwr != m_rxrel) begin
      read16(RXB + (m_rxrel & MSK), hdr);
      hread(RXB + ((m_rxrel + 16'd1) & MSK), b);
      hdr = {hdr[15:8], b};
      chk("R8 header length", hdr, {rxm[m_rxrel & MSK], rxm[(m_rxrel + 16'd1) & MSK]});
      for (int i = 2; i < int'(hdr); i++) begin
        hread(RXB + ((m_rxrel + 16'(i)) & MSK), b);
        chk("R5 R8 rx ring byte", b, rxm[(m_rxrel + 16'(i)) & MSK]);
      end
      write16(A_RRD, m_rxrel + hdr);
      read16(A_RRD, v);
      chk("R3 rx read pointer readback", v, m_rxrel + hdr);
      read16(A_RSZ, v);
      chk("R10 size held before release", v, m_rxwr - m_rxrel);
      hwrite(A_CMD, 8'h40);
      m_rxrel = m_rxrel + hdr;
      read16(A_RSZ, v);
      chk("R10 size after release", v, m_rxwr - m_rxrel);
    end
    read16(A_RSZ, v);
    chk("R11 size zero when drained", v, 16'd0);
  endtask

  initial begin
    logic [15:0] v, old;
    logic [7:0]  e;
    bit          acc;
    int          n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk("R1 tx_valid low", tx_valid, 1'b0);
    read16(A_FREE, v); chk("R1 tx free", v, 16'(RB));
    read16(A_TRD, v);  chk("R1 tx rd", v, 16'd0);
    read16(A_TWR, v);  chk("R1 tx wr", v, 16'd0);
    read16(A_RSZ, v);  chk("R1 R11 rx size", v, 16'd0);
    read16(A_RRD, v);  chk("R1 rx rd", v, 16'd0);
    hread(A_EVT, e);   chk("R1 events", e, 8'h00);

    // send with equal pointers completes at once
    hwrite(A_CMD, 8'h20);
    wait_sent();

    // random sends that wrap the ring
    for (int t = 0; t < 14; t++) begin
      n = 1 + int'($urandom % 40);
      fill_tx(n, 0);
      m_txwr = m_txwr + 16'(n);
      write16(A_TWR, m_txwr);
      read16(A_TWR, v); chk("R3 tx wr readback", v, m_txwr);
      read16(A_FREE, v); chk("R4 free before send", v, tx_free_exp(m_txwr, m_txwr - 16'(n)));
      cap_n = 0;
      hwrite(A_CMD, 8'h20);
      wait_sent();
      chk("R6 byte count", cap_n, n);
      for (int i = 0; i < n; i++) chk("R5 R6 tx byte", cap[i], exp_tx[i]);
      read16(A_TRD, v); chk("R6 rd reaches wr", v, m_txwr);
      read16(A_FREE, v); chk("R4 free after send", v, 16'(RB));
    end

    // send while busy is ignored
    sink_en = 0;
    fill_tx(3, 0);
    m_txwr = m_txwr + 16'd3;
    write16(A_TWR, m_txwr);
    cap_n = 0;
    hwrite(A_CMD, 8'h20);
    repeat (3) @(negedge clk);
    chk("R6 valid while stalled", tx_valid, 1'b1);
    fill_tx(2, 3);
    m_txwr = m_txwr + 16'd2;
    write16(A_TWR, m_txwr);
    hwrite(A_CMD, 8'h20);
    sink_en = 1;
    wait_sent();
    chk("R6 busy send ignored count", cap_n, 3);
    for (int i = 0; i < 3; i++) chk("R6 first batch byte", cap[i], exp_tx[i]);
    read16(A_TRD, v); chk("R6 rd after first batch", v, m_txwr - 16'd2);
    read16(A_FREE, v); chk("R4 free with 2 pending", v, 16'(RB - 2));
    cap_n = 0;
    hwrite(A_CMD, 8'h20);
    wait_sent();
    chk("R6 second batch count", cap_n, 2);
    for (int i = 0; i < 2; i++) chk("R6 second batch byte", cap[i], exp_tx[3 + i]);

    // ignored commands and read-only writes
    hwrite(A_CMD, 8'h55);
    write16(A_FREE, 16'h1234);
    write16(A_TRD, 16'h0033);
    write16(A_RSZ, 16'h0044);
    repeat (4) @(negedge clk);
    chk("R12 no transfer started", tx_valid, 1'b0);
    read16(A_FREE, v); chk("R12 free unchanged", v, 16'(RB));
    read16(A_TRD, v);  chk("R12 tx rd unchanged", v, m_txwr);
    read16(A_RSZ, v);  chk("R12 rx size unchanged", v, 16'd0);

    // random receive traffic
    for (int t = 0; t < 16; t++) begin
      n = int'($urandom % 24);
      old = m_rxwr - m_rxrel;
      rx_frame(n, acc);
      read16(A_RSZ, v);
      if (acc) chk("R8 size grows", v, old + 16'(n + 2));
      else     chk("R9 size kept on drop", v, old);
      hread(A_EVT, e);
      chk("R8 R9 receive event", e[2], acc);
      hwrite(A_EVT, 8'h04);
      hread(A_EVT, e);
      chk("R8 receive event cleared", e[2], 1'b0);
      if (($urandom % 3) == 0) drain();
    end
    drain();

    // drop boundary: exact fill accepted, overflow dropped
    rx_frame(20, acc); chk("R9 first frame fits", acc, 1'b1);
    rx_frame(20, acc); chk("R9 second frame fits", acc, 1'b1);
    hwrite(A_EVT, 8'h04);
    rx_frame(20, acc);
    read16(A_RSZ, v); chk("R9 overflow dropped", v, 16'd44);
    hread(A_EVT, e);  chk("R9 no event on drop", e[2], 1'b0);
    rx_frame(18, acc);
    read16(A_RSZ, v); chk("R9 exact fill accepted", v, 16'(RB));
    rx_frame(0, acc);
    read16(A_RSZ, v); chk("R9 header-only frame dropped when full", v, 16'(RB));
    drain();

    // snapshot: low byte comes from the capture at the high read
    hread(A_RSZ, e);
    chk("R2 size high byte", e, 8'h00);
    rx_frame(5, acc);
    hread(A_RSZ + 16'd1, e);
    chk("R2 low byte from snapshot", e, 8'h00);
    read16(A_RSZ, v);
    chk("R2 fresh pair read", v, 16'd7);
    drain();

    finished = 1;
    report();
  end
endmodule